// File: doc/BRIEF.md
# External Wakeup Interrupt Flag Unit

This block watches a set of external pad lines plus one non-maskable line and turns level transitions on them into latched event flags. The rising and falling directions can be enabled separately for each pad. A pad event that is enabled sets that pad's status bit. The bit stays set until software writes a one to it.

A flag raises the combined interrupt output only when its interrupt-enable bit is set. The wakeup output, by contrast, follows any set flag whatever its enable. The non-maskable line has its own pair of direction enables and an optional digital filter. It does not latch a flag. It produces a single-cycle request pulse instead.

Software reaches every setting and the status bits through a simple word-wide read/write port. Reads are combinational and writes take effect at a clock edge.

Top module: `extwake_flag_unit`

## Requirements
- R1: The status register at offset 0x14 holds the pad flags in bits 20:0, with bit i belonging to pad i. Bits 31:21 always read zero, and every flag is zero after reset.
- R2: A rising edge on pad i sets flag i only when bit i of the rising-enable register (offset 0x18) is one. A falling edge sets it only when bit i of the falling-enable register (offset 0x1C) is one. An edge in a disabled direction leaves the flag unchanged.
- R3: A write to the status register with bit i equal to one clears flag i. A bit written as zero leaves its flag unchanged.
- R4: `irqOut` is high exactly when some flag i is set and bit i of the interrupt-enable register (offset 0x20) is one.
- R5: `wakeOut` is high whenever any flag is set, whatever the interrupt enables hold.
- R6: The NMI configuration register at offset 0x00 enables NMI rising edges with bit 5 and falling edges with bit 6. An enabled NMI edge produces a `nmiReq` pulse one cycle long, and `wakeOut` is high during that cycle. With bits 5 and 6 both zero, NMI activity produces no request.
- R7: When bit 7 of the NMI configuration register is one, a new NMI level is accepted only after it has been stable for 4 consecutive clocks, so a pulse 3 clocks wide produces no request. When bit 7 is zero the filter is bypassed.
- R8: If an edge event and a write of one to the same flag occur in the same cycle, the flag ends up set.
- R9: A pad change first captured at clock edge k shows in the status register after edge k+2. It does not show before that edge. An NMI request is high for the cycle after edge k+2 when the filter is bypassed, and for the cycle after edge k+6 when the filter is on.
- R10: The rising-enable, falling-enable, interrupt-enable and NMI configuration registers read back the values last written (NMI bits 5..7 only), and they reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| padIn | input | 21 | Asynchronous external pad lines |
| nmiPad | input | 1 | Asynchronous non-maskable line |
| irqOut | output | 1 | Combined interrupt request |
| wakeOut | output | 1 | Wakeup request |
| nmiReq | output | 1 | Non-maskable request pulse |

## Verification
A pad change is driven on a falling clock edge. Status, `irqOut` and `wakeOut` must still show the old value two falling edges later and the new value three falling edges later. The bench samples at exactly those two points for the latency check, and at four falling edges everywhere else. An NMI pulse is due on the third falling edge after the drive when the filter is off, and on the seventh when it is on. The bench checks that the pulse is present at that point and absent one edge before and one edge after. In the same-cycle clear test, the status write is placed so that it is captured at the very edge on which the new event registers.

// File: rtl/wk_pkg.sv
package wk_pkg;
  // NMI configuration bit positions inside the word at offset 0x00
  localparam int NMI_RISE_BIT = 5;
  localparam int NMI_FALL_BIT = 6;
  localparam int NMI_FILT_BIT = 7;

  typedef struct packed {
    logic nmiRise;
    logic nmiFall;
    logic nmiFilt;
  } nmiCfg_t;

  // strobes from the register control to the datapath
  typedef struct packed {
    logic clrFlags;
  } wkStrobe_t;
endpackage

// File: rtl/wk_ctrl.sv
module wk_ctrl
  import wk_pkg::*;
#(
  parameter int NUM_PADS = 21,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PADS-1:0] flagsQ,
  output logic [NUM_PADS-1:0] riseEn,
  output logic [NUM_PADS-1:0] fallEn,
  output logic [NUM_PADS-1:0] irqEn,
  output nmiCfg_t             nmiCfg,
  output wkStrobe_t           strobe,
  output logic [NUM_PADS-1:0] clrMask
);
  localparam logic [ADDR_W-1:0] OFS_NMI  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_RISE = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_FALL = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFS_IRQ  = ADDR_W'(8'h20);

  logic wrHit;
  logic unusedWdata;

  assign wrHit       = busSel && busWr;
  assign unusedWdata = ^busWdata[DATA_W-1:NUM_PADS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseEn <= '0;
      fallEn <= '0;
      irqEn  <= '0;
      nmiCfg <= '0;
    end else if (wrHit) begin
      case (busAddr)
        OFS_RISE: riseEn <= busWdata[NUM_PADS-1:0];
        OFS_FALL: fallEn <= busWdata[NUM_PADS-1:0];
        OFS_IRQ:  irqEn  <= busWdata[NUM_PADS-1:0];
        OFS_NMI: begin
          nmiCfg.nmiRise <= busWdata[NMI_RISE_BIT];
          nmiCfg.nmiFall <= busWdata[NMI_FALL_BIT];
          nmiCfg.nmiFilt <= busWdata[NMI_FILT_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clrFlags = wrHit && (busAddr == OFS_STAT);
    clrMask         = busWdata[NUM_PADS-1:0];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_STAT: busRdata[NUM_PADS-1:0] = flagsQ;
      OFS_RISE: busRdata[NUM_PADS-1:0] = riseEn;
      OFS_FALL: busRdata[NUM_PADS-1:0] = fallEn;
      OFS_IRQ:  busRdata[NUM_PADS-1:0] = irqEn;
      OFS_NMI: begin
        busRdata[NMI_RISE_BIT] = nmiCfg.nmiRise;
        busRdata[NMI_FALL_BIT] = nmiCfg.nmiFall;
        busRdata[NMI_FILT_BIT] = nmiCfg.nmiFilt;
      end
      default: ;
    endcase
  end

  // R1: the upper status bits never carry data
  p_stat_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFS_STAT) |-> (busRdata[DATA_W-1:NUM_PADS] == '0));

  // R10: a register changes only through a write to its own offset
  p_rise_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrHit && busAddr == OFS_RISE) |=> $stable(riseEn));
endmodule

// File: rtl/wk_datapath.sv
module wk_datapath
  import wk_pkg::*;
#(
  parameter int NUM_PADS    = 21,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic                nmiPad,
  input  logic [NUM_PADS-1:0] riseEn,
  input  logic [NUM_PADS-1:0] fallEn,
  input  logic [NUM_PADS-1:0] irqEn,
  input  nmiCfg_t             nmiCfg,
  input  wkStrobe_t           strobe,
  input  logic [NUM_PADS-1:0] clrMask,
  output logic [NUM_PADS-1:0] flagsQ,
  output logic                irqOut,
  output logic                wakeOut,
  output logic                nmiReq
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_STAGES-1:0][NUM_PADS-1:0] padSync;
  logic [SYNC_STAGES-1:0]               nmiSync;
  logic [NUM_PADS-1:0] padNow, padPrev, setVec, clrEff;
  logic nmiNow, nmiFilt, nmiSel, nmiPrev, nmiEdge;

  // synchronizer chains
  always_ff @(posedge clk) begin
    if (!rstN) begin
      padSync <= '0;
      nmiSync <= '0;
    end else begin
      padSync[0] <= padIn;
      nmiSync[0] <= nmiPad;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        padSync[s] <= padSync[s-1];
        nmiSync[s] <= nmiSync[s-1];
      end
    end
  end

  assign padNow = padSync[SYNC_STAGES-1];
  assign nmiNow = nmiSync[SYNC_STAGES-1];

  // pad edge detection and flag update (event beats clear)
  always_comb begin
    setVec = ((padNow & ~padPrev) & riseEn) | ((~padNow & padPrev) & fallEn);
    clrEff = strobe.clrFlags ? clrMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      padPrev <= '0;
      flagsQ  <= '0;
    end else begin
      padPrev <= padNow;
      flagsQ  <= (flagsQ & ~clrEff) | setVec;
    end
  end

  // NMI digital filter variant chosen by FILT_LEN
  generate
    if (FILT_LEN > 1) begin : g_filt
      logic [CNT_W-1:0] stableCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          nmiFilt   <= 1'b0;
          stableCnt <= '0;
        end else if (nmiNow != nmiFilt) begin
          if (stableCnt == CNT_W'(FILT_LEN-1)) begin
            nmiFilt   <= nmiNow;
            stableCnt <= '0;
          end else begin
            stableCnt <= stableCnt + 1'b1;
          end
        end else begin
          stableCnt <= '0;
        end
      end
      // R7: the filtered level moves only after a full stable window
      p_filt_window_r7: assert property (@(posedge clk) disable iff (!rstN)
        (nmiFilt != $past(nmiFilt)) |-> ($past(stableCnt) == CNT_W'(FILT_LEN-1)));
    end else begin : g_nofilt
      assign nmiFilt = nmiNow;
    end
  endgenerate

  assign nmiSel  = nmiCfg.nmiFilt ? nmiFilt : nmiNow;
  assign nmiEdge = (nmiSel & ~nmiPrev & nmiCfg.nmiRise) |
                   (~nmiSel & nmiPrev & nmiCfg.nmiFall);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiReq  <= 1'b0;
    end else begin
      nmiPrev <= nmiSel;
      nmiReq  <= nmiEdge;
    end
  end

  assign irqOut  = |(flagsQ & irqEn);
  assign wakeOut = (|flagsQ) | nmiReq;

  // R2: a flag rises only from an enabled edge
  p_set_needs_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((flagsQ & ~$past(flagsQ) & ~$past(setVec)) == '0));
  // R3: a flag falls only when software wrote a one to it
  p_clear_needs_w1_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((~flagsQ & $past(flagsQ) & ~$past(clrEff)) == '0));
  // R8: an event always leaves its flag set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(setVec) & ~flagsQ) == '0));
  // R4: no interrupt while every enable is off
  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == '0) |-> !irqOut);
  // R5: an interrupt always implies a wakeup
  p_irq_wakes_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> wakeOut);
  // R6: NMI fully silent when both directions are off
  p_nmi_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(!nmiCfg.nmiRise && !nmiCfg.nmiFall) |-> !nmiReq);
endmodule

// File: rtl/extwake_flag_unit.sv
module extwake_flag_unit
  import wk_pkg::*;
#(
  parameter int NUM_PADS    = 21,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic                nmiPad,
  output logic                irqOut,
  output logic                wakeOut,
  output logic                nmiReq
);
  logic [NUM_PADS-1:0] flagsQ, riseEn, fallEn, irqEn, clrMask;
  nmiCfg_t   nmiCfg;
  wkStrobe_t strobe;

  wk_ctrl #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .flagsQ(flagsQ), .riseEn(riseEn), .fallEn(fallEn), .irqEn(irqEn),
    .nmiCfg(nmiCfg), .strobe(strobe), .clrMask(clrMask)
  );

  wk_datapath #(.NUM_PADS(NUM_PADS), .SYNC_STAGES(SYNC_STAGES),
                .FILT_LEN(FILT_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .padIn(padIn), .nmiPad(nmiPad),
    .riseEn(riseEn), .fallEn(fallEn), .irqEn(irqEn), .nmiCfg(nmiCfg),
    .strobe(strobe), .clrMask(clrMask), .flagsQ(flagsQ),
    .irqOut(irqOut), .wakeOut(wakeOut), .nmiReq(nmiReq)
  );
endmodule

// File: tb/sim_extwake_flag_unit.sv
`timescale 1ns/1ps
module sim_extwake_flag_unit;
  localparam int NP = 21;
  localparam logic [7:0] A_NMI = 8'h00, A_STAT = 8'h14, A_RISE = 8'h18,
                         A_FALL = 8'h1C, A_IRQ = 8'h20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NP-1:0] padIn = '0;
  logic nmiPad = 1'b0;
  logic irqOut, wakeOut, nmiReq;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;

  logic [NP-1:0] expFlags = '0;
  logic [NP-1:0] curRise = '0, curFall = '0, curIrq = '0;

  always #10 clk = ~clk;

  extwake_flag_unit u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .nmiPad(nmiPad), .irqOut(irqOut),
    .wakeOut(wakeOut), .nmiReq(nmiReq)
  );

  function automatic logic [NP-1:0] edgeSet(input logic [NP-1:0] oldV, newV,
                                            input logic [NP-1:0] re, fe);
    return ((~oldV & newV) & re) | ((oldV & ~newV) & fe);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic checkStatus(input string req, input string what);
    logic [31:0] rd;
    busRead(A_STAT, rd);
    check(rd == {11'b0, expFlags}, req, what, rd, {11'b0, expFlags});
    check(irqOut == |(expFlags & curIrq), "R4", {what, " irq"}, 32'(irqOut),
          32'(|(expFlags & curIrq)));
    check(wakeOut == |expFlags, "R5", {what, " wake"}, 32'(wakeOut), 32'(|expFlags));
  endtask

  task automatic drivePads(input logic [NP-1:0] v);
    @(negedge clk);
    expFlags |= edgeSet(padIn, v, curRise, curFall);
    padIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clearFlags(input logic [NP-1:0] m);
    busWrite(A_STAT, {11'b0, m});
    expFlags &= ~m;
  endtask

  task automatic setCfg(input logic [NP-1:0] r, f, i);
    busWrite(A_RISE, {11'b0, r}); curRise = r;
    busWrite(A_FALL, {11'b0, f}); curFall = f;
    busWrite(A_IRQ,  {11'b0, i}); curIrq  = i;
  endtask

  // count nmiReq pulses over a window, sampled at falling edges
  task automatic countNmi(input int cycles, output int cnt);
    cnt = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (nmiReq) cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired actual=%0d expected=0", nChecks);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cnt;
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 / R10: reset state
    busRead(A_STAT, rd); check(rd == 0, "R1", "status after reset", rd, 0);
    busRead(A_RISE, rd); check(rd == 0, "R10", "rise enable reset", rd, 0);
    busRead(A_NMI, rd);  check(rd == 0, "R10", "nmi cfg reset", rd, 0);
    check(!irqOut && !wakeOut && !nmiReq, "R4", "outputs after reset",
          {29'b0, irqOut, wakeOut, nmiReq}, 0);

    // R10: readback
    setCfg(21'h0F0F0F, 21'h1A5A5A, 21'h000FFF);
    busRead(A_RISE, rd); check(rd == 32'h0F0F0F, "R10", "rise readback", rd, 32'h0F0F0F);
    busRead(A_FALL, rd); check(rd == 32'h1A5A5A, "R10", "fall readback", rd, 32'h1A5A5A);
    busRead(A_IRQ, rd);  check(rd == 32'h000FFF, "R10", "irq readback", rd, 32'h000FFF);
    busWrite(A_NMI, 32'hFFFF_FFFF);
    busRead(A_NMI, rd);  check(rd == 32'hE0, "R10", "nmi cfg readback", rd, 32'hE0);
    busWrite(A_NMI, 32'h0);

    // R2: rising only on pad 0, falling only on pad 1
    setCfg(21'h000001, 21'h000002, 21'h000000);
    drivePads(21'h000003);
    checkStatus("R2", "rise pad0 only");
    drivePads(21'h000000);
    checkStatus("R2", "fall pad1 only");

    // R3: writing zero has no effect, writing one clears
    clearFlags(21'h000000);
    checkStatus("R3", "w1c zero write");
    clearFlags(21'h000001);
    checkStatus("R3", "w1c clears pad0");

    // R4 / R5: interrupt gating vs wakeup
    curIrq = 21'h000001; busWrite(A_IRQ, 32'h1);
    checkStatus("R4", "pad1 flag, irq on pad0 only");
    curIrq = 21'h000002; busWrite(A_IRQ, 32'h2);
    checkStatus("R4", "pad1 flag, irq on pad1");
    clearFlags(21'h1FFFFF);
    checkStatus("R5", "all cleared");

    // R9: status latency, drive on negedge, old at 2nd, new at 3rd negedge
    setCfg(21'h000010, 21'h000000, 21'h000000);
    @(negedge clk);
    padIn = 21'h000010;
    repeat (2) @(negedge clk);
    busAddr = A_STAT; #1;
    check(busRdata == 0, "R9", "status before edge k+2", busRdata, 0);
    @(negedge clk); #1;
    check(busRdata == 32'h10, "R9", "status after edge k+2", busRdata, 32'h10);
    expFlags = 21'h000010;
    repeat (2) @(negedge clk);

    // R8: event and clear of the same flag in the same cycle
    setCfg(21'h000010, 21'h000010, 21'h000000);
    @(negedge clk);
    padIn = 21'h000000;
    @(negedge clk);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = A_STAT; busWdata = 32'h10;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    checkStatus("R8", "set beats clear");
    clearFlags(21'h000010);
    checkStatus("R3", "clear after collision");

    // R6: NMI off -> nothing
    busWrite(A_NMI, 32'h0);
    @(negedge clk); nmiPad = 1'b1;
    countNmi(10, cnt);
    check(cnt == 0 && !wakeOut, "R6", "nmi disabled", cnt, 0);
    @(negedge clk); nmiPad = 1'b0;
    countNmi(10, cnt);

    // R6 / R9: bypass rise pulse at 3rd negedge, one cycle
    busWrite(A_NMI, 32'h20);
    @(negedge clk); nmiPad = 1'b1;
    repeat (2) @(negedge clk);
    check(!nmiReq, "R9", "nmi bypass before due", nmiReq, 0);
    @(negedge clk);
    check(nmiReq && wakeOut, "R6", "nmi bypass pulse due", {nmiReq, wakeOut}, 2'b11);
    @(negedge clk);
    check(!nmiReq, "R6", "nmi pulse one cycle", nmiReq, 0);
    @(negedge clk); nmiPad = 1'b0;
    countNmi(10, cnt);
    check(cnt == 0, "R6", "falling edge disabled", cnt, 0);

    // R7: filter on, 3-clock glitch rejected
    busWrite(A_NMI, 32'hA0);
    repeat (6) @(negedge clk);
    nmiPad = 1'b1;
    repeat (3) @(negedge clk);
    nmiPad = 1'b0;
    countNmi(12, cnt);
    check(cnt == 0, "R7", "3-clock glitch filtered", cnt, 0);

    // R7 / R9: stable level accepted, pulse at 7th negedge
    nmiPad = 1'b1;
    repeat (6) @(negedge clk);
    check(!nmiReq, "R9", "filtered nmi before due", nmiReq, 0);
    @(negedge clk);
    check(nmiReq, "R7", "filtered nmi pulse due", nmiReq, 1);
    @(negedge clk);
    check(!nmiReq, "R7", "filtered pulse one cycle", nmiReq, 0);
    busWrite(A_NMI, 32'h0);
    @(negedge clk); nmiPad = 1'b0;
    repeat (8) @(negedge clk);

    // constrained random: R2 R3 R4 R5
    for (int it = 0; it < 40; it++) begin
      if (it % 8 == 0)
        setCfg(NP'($urandom), NP'($urandom), NP'($urandom));
      drivePads(padIn ^ NP'($urandom & $urandom));
      checkStatus("R2", "random edges");
      clearFlags(NP'($urandom));
      checkStatus("R3", "random clear");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule